// File: doc/BRIEF.md
# 4x4 Luma Intra Predictor

This block forms the intra prediction for one 4x4 luma sub-block of a video decoder. It takes the thirteen reconstructed neighbour pixels around the sub-block: eight above (columns 0 to 7, the last four being the upper-right extension), four to the left (rows 0 to 3) and the one at the upper-left corner. It also takes three availability flags and a 4-bit mode code, and returns sixteen predicted pixels. All nine prediction modes are evaluated in parallel. A first stage forms the shared pairwise sums of adjacent neighbours. A second stage derives the three-tap sums, the end-of-edge sums and the DC totals from them. A shift stage then turns these into two-tap averages, three-tap filtered values and the DC value. A final select stage picks the requested mode's value for each pixel position.

A caller pulses `start` for one cycle with the neighbours, flags and mode on the inputs. Exactly six cycles later `done` pulses for one cycle and the prediction appears on `pred`, where it stays until the next result replaces it. A new request may be issued on any cycle, so one sub-block per cycle can be streamed.

Top module: `intra4x4_predictor`

## Requirements
- R1: When `start` is high in cycle c, `done` is high in cycle c+6 only and low in cycles c+1 to c+5 (one-cycle pulse per request).
- R2: `pred` changes only in a cycle where `done` is high and otherwise keeps its value, whatever the inputs do.
- R3: Mode 0 (vertical) with the top available: every pixel in column x equals the top neighbour of column x.
- R4: Mode 1 (horizontal) with the left available: every pixel in row y equals the left neighbour of row y.
- R5: Mode 2 (DC) fills all 16 pixels with (sum of top 0..3 and left 0..3 + 4) >> 3 when both sides are available, (sum of the four available pixels + 2) >> 2 when exactly one side is, and 128 when neither is.
- R6: Modes 3 (down-left diagonal) and 4 (down-right diagonal) produce the three-tap value (a + 2b + c + 2) >> 2 along their diagonal. Position (3,3) of mode 3 uses (top6 + 3*top7 + 2) >> 2.
- R7: Modes 5 (vertical-right) and 6 (horizontal-down) mix two-tap averages (a + b + 1) >> 1 and three-tap values, per the standard 4x4 zig-zag rules.
- R8: Modes 7 (vertical-left) and 8 (horizontal-up) follow the same rules. Mode 8 uses (left2 + 3*left3 + 2) >> 2 at the position where x + 2y = 5, and left3 beyond it.
- R9: When the upper-right flag is low, top neighbours 4 to 7 are taken as copies of top neighbour 3.
- R10: When the mode code is 9 to 15, or the requested mode needs a side that is not available, the DC prediction of R5 is produced instead. Modes 0, 3 and 7 need the top; modes 1 and 8 need the left; modes 4, 5 and 6 need both.
- R11: After reset `done` is low and `pred` is all zero until the first result.
- R12: Pixel (x,y) of the block, x the column and y the row, occupies `pred` bits [8*(4y+x)+7 : 8*(4y+x)]. Top neighbour i sits at `top_pix` bits [8i+7:8i] and left neighbour j at `left_pix` bits [8j+7:8j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; inputs are captured in this cycle |
| mode | input | 4 | Prediction mode code, 0 to 8 valid |
| top_pix | input | 64 | Top neighbours 0..7, neighbour 0 in the low byte |
| left_pix | input | 32 | Left neighbours 0..3, neighbour 0 in the low byte |
| corner_pix | input | 8 | Upper-left corner neighbour |
| top_ok | input | 1 | Top neighbours 0..3 available |
| topright_ok | input | 1 | Top neighbours 4..7 available |
| left_ok | input | 1 | Left neighbours available |
| pred | output | 128 | Sixteen predicted pixels in raster order |
| done | output | 1 | Result valid pulse |

## Verification
Each request's result is due in the sixth cycle after the cycle in which `start` was high. The bench samples `done` and `pred` on the falling edge of that cycle. It also samples `done` one cycle earlier, to see it still low, and one cycle later, to see it low again with `pred` unchanged. The sweep covers every mode code, every availability combination and several neighbour patterns, including all-maximum and all-zero. Expected pixels come from the prediction formulas evaluated in the bench. To show that `pred` holds, the bench scrambles the inputs without a start, waits several cycles and compares `pred` again.

// File: rtl/intra4_pkg.sv
`timescale 1ns/1ps
package intra4_pkg;
   localparam int NEDGE  = 13;   // L,K,J,I,corner,A..H along the block boundary
   localparam int NPAIR  = 12;
   localparam int NAVG   = 10;
   localparam int NF3    = 11;
   localparam int NRAW   = 8;
   localparam int NMODE  = 9;
   localparam int NPIX   = 16;
   localparam int C_AVG  = 0;
   localparam int C_F3   = C_AVG + NAVG;
   localparam int C_GEND = C_F3 + NF3;
   localparam int C_LEND = C_GEND + 1;
   localparam int C_DC   = C_LEND + 1;
   localparam int C_RAW  = C_DC + 1;
   localparam int NCAND  = C_RAW + NRAW;

   typedef enum logic [3:0] {
      PM_VERT = 4'd0, PM_HORZ = 4'd1, PM_DC = 4'd2, PM_DDL = 4'd3, PM_DDR = 4'd4,
      PM_VR = 4'd5, PM_HD = 4'd6, PM_VL = 4'd7, PM_HU = 4'd8
   } pmode_e;

   // three-tap value centred on boundary index c
   function automatic int f3c(int c);
      return C_F3 + c - 1;
   endfunction

   // candidate index used by mode m at column x, row y
   function automatic int sel_idx(int m, int x, int y);
      int z;
      z = 0;
      case (m)
         0: return C_RAW + 4 + x;
         1: return C_RAW + 3 - y;
         3: if (x == 3 && y == 3) return C_GEND; else return f3c(6 + x + y);
         4: return f3c(4 + x - y);
         5: begin
            z = 2 * x - y;
            if (z >= 0 && (z % 2) == 0) return C_AVG + 4 + x - (y >> 1);
            else if (z > 0)             return f3c(4 + x - (y >> 1));
            else if (z == -1)           return f3c(4);
            else                        return f3c(5 - y);
         end
         6: begin
            z = 2 * y - x;
            if (z >= 0 && (z % 2) == 0) return C_AVG + 3 - y + (x >> 1);
            else if (z > 0)             return f3c(4 - y + (x >> 1));
            else if (z == -1)           return f3c(4);
            else                        return f3c(3 + x);
         end
         7: if ((y % 2) == 0) return C_AVG + 5 + x + (y >> 1);
            else              return f3c(6 + x + (y >> 1));
         8: begin
            z = x + 2 * y;
            if (z > 5)              return C_RAW;
            else if (z == 5)        return C_LEND;
            else if ((z % 2) == 0)  return C_AVG + 2 - (y + (x >> 1));
            else                    return f3c(2 - (y + (x >> 1)));
         end
         default: return C_DC;
      endcase
   endfunction

   // mode actually produced, given which sides exist
   function automatic logic [3:0] eff_mode(logic [3:0] m, logic t_ok, logic l_ok);
      logic ok;
      case (m)
         PM_VERT, PM_DDL, PM_VL: ok = t_ok;
         PM_HORZ, PM_HU:         ok = l_ok;
         PM_DC:                  ok = 1'b1;
         PM_DDR, PM_VR, PM_HD:   ok = t_ok & l_ok;
         default:                ok = 1'b0;
      endcase
      return ok ? m : PM_DC;
   endfunction
endpackage

// File: rtl/intra4_sums.sv
`timescale 1ns/1ps
module intra4_sums import intra4_pkg::*; #(
   parameter int PIX_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NEDGE-1:0][PIX_W-1:0]         edge_q,
   output logic [NF3-1:0][PIX_W+1:0]           tri_q,
   output logic [PIX_W+1:0]                    gend_q,
   output logic [PIX_W+1:0]                    lend_q,
   output logic [PIX_W+2:0]                    dcb_q,
   output logic [PIX_W+1:0]                    dct_q,
   output logic [PIX_W+1:0]                    dcl_q,
   output logic [NAVG-1:0][PIX_W:0]            pair_q,
   output logic [NRAW-1:0][PIX_W-1:0]          raw_q
);
   localparam int SW = PIX_W + 1;
   localparam int TW = PIX_W + 2;

   // stage 2: shared pairwise sums and side totals
   logic [NPAIR-1:0][SW-1:0]    pr_n, pr_r;
   logic [TW-1:0]               st_n, sl_n, st_r, sl_r;
   logic [NRAW-1:0][PIX_W-1:0]  raw_n, raw_r;
   logic [PIX_W-1:0]            h_r;

   always_comb begin
      for (int i = 0; i < NPAIR; i++)
         pr_n[i] = {1'b0, edge_q[i]} + {1'b0, edge_q[i+1]};
      st_n = '0;
      sl_n = '0;
      for (int i = 0; i < 4; i++) begin
         sl_n = sl_n + TW'(edge_q[i]);
         st_n = st_n + TW'(edge_q[5+i]);
         raw_n[i]   = edge_q[i];
         raw_n[4+i] = edge_q[5+i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_r <= '0; st_r <= '0; sl_r <= '0; raw_r <= '0; h_r <= '0;
      end else begin
         pr_r <= pr_n; st_r <= st_n; sl_r <= sl_n; raw_r <= raw_n;
         h_r  <= edge_q[NEDGE-1];
      end
   end

   // stage 3: derived sums built only from the shared pairs
   logic [NF3-1:0][TW-1:0] tri_n;
   always_comb begin
      for (int i = 0; i < NF3; i++)
         tri_n[i] = {1'b0, pr_r[i]} + {1'b0, pr_r[i+1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tri_q <= '0; gend_q <= '0; lend_q <= '0; dcb_q <= '0;
         dct_q <= '0; dcl_q <= '0; pair_q <= '0; raw_q <= '0;
      end else begin
         tri_q  <= tri_n;
         gend_q <= {1'b0, pr_r[NPAIR-1]} + {1'b0, h_r, 1'b0};
         lend_q <= {1'b0, pr_r[0]} + {1'b0, raw_r[0], 1'b0};
         dcb_q  <= {1'b0, st_r} + {1'b0, sl_r};
         dct_q  <= st_r;
         dcl_q  <= sl_r;
         pair_q <= pr_r[NAVG-1:0];
         raw_q  <= raw_r;
      end
   end
endmodule

// File: rtl/intra4_shift.sv
`timescale 1ns/1ps
module intra4_shift import intra4_pkg::*; #(
   parameter int PIX_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NF3-1:0][PIX_W+1:0]     tri_q,
   input  logic [PIX_W+1:0]              gend_q,
   input  logic [PIX_W+1:0]              lend_q,
   input  logic [PIX_W+2:0]              dcb_q,
   input  logic [PIX_W+1:0]              dct_q,
   input  logic [PIX_W+1:0]              dcl_q,
   input  logic [NAVG-1:0][PIX_W:0]      pair_q,
   input  logic [NRAW-1:0][PIX_W-1:0]    raw_q,
   input  logic                          top_ok,
   input  logic                          left_ok,
   output logic [NCAND-1:0][PIX_W-1:0]   cand_q
);
   localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);
   logic [NCAND-1:0][PIX_W-1:0] cand_n;

   genvar i;
   generate
      for (i = 0; i < NAVG; i++) begin : g_avg
         logic [PIX_W:0] rnd;
         assign rnd = pair_q[i] + 1'b1;
         assign cand_n[C_AVG+i] = rnd[PIX_W:1];
      end
      for (i = 0; i < NF3; i++) begin : g_tri
         logic [PIX_W+1:0] rnd;
         assign rnd = tri_q[i] + 2'd2;
         assign cand_n[C_F3+i] = rnd[PIX_W+1:2];
      end
      for (i = 0; i < NRAW; i++) begin : g_raw
         assign cand_n[C_RAW+i] = raw_q[i];
      end
   endgenerate

   logic [PIX_W+1:0] ge_r, le_r, ct_r, cl_r;
   logic [PIX_W+2:0] cb_r;
   assign ge_r = gend_q + 2'd2;
   assign le_r = lend_q + 2'd2;
   assign ct_r = dct_q + 2'd2;
   assign cl_r = dcl_q + 2'd2;
   assign cb_r = dcb_q + 3'd4;
   assign cand_n[C_GEND] = ge_r[PIX_W+1:2];
   assign cand_n[C_LEND] = le_r[PIX_W+1:2];

   always_comb begin
      case ({top_ok, left_ok})
         2'b11:   cand_n[C_DC] = cb_r[PIX_W+2:3];
         2'b10:   cand_n[C_DC] = ct_r[PIX_W+1:2];
         2'b01:   cand_n[C_DC] = cl_r[PIX_W+1:2];
         default: cand_n[C_DC] = MID;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cand_q <= '0;
      else        cand_q <= cand_n;
   end

   // R5: no neighbours at all gives the mid-level DC value
   assert_dc_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!top_ok && !left_ok) |=> (cand_q[C_DC] == MID));
endmodule

// File: rtl/intra4_select.sv
`timescale 1ns/1ps
module intra4_select import intra4_pkg::*; #(
   parameter int PIX_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NCAND-1:0][PIX_W-1:0]   cand_q,
   input  logic [3:0]                    mode_q,
   input  logic                          top_ok,
   input  logic                          left_ok,
   input  logic                          load,
   output logic [NPIX-1:0][PIX_W-1:0]    pix_q
);
   logic [NCAND-1:0][PIX_W-1:0] cand_r;
   logic [3:0]                  eff_r;
   logic [NPIX-1:0][PIX_W-1:0]  pix_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_r <= '0;
         eff_r  <= PM_DC;
      end else begin
         cand_r <= cand_q;
         eff_r  <= eff_mode(mode_q, top_ok, left_ok);
      end
   end

   genvar p, m;
   generate
      for (p = 0; p < NPIX; p++) begin : g_pix
         logic [NMODE-1:0][PIX_W-1:0] opt;
         for (m = 0; m < NMODE; m++) begin : g_mode
            localparam int IDX = sel_idx(m, p % 4, p / 4);
            assign opt[m] = cand_r[IDX];
         end
         assign pix_n[p] = opt[eff_r];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pix_q <= '0;
      else if (load) pix_q <= pix_n;
   end

   // R10: unknown codes fall back to DC, and no code beyond 8 reaches the mux
   assert_fallback_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q > 4'd8) |=> (eff_r == PM_DC));
   assert_mode_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eff_r <= 4'd8);
endmodule

// File: rtl/intra4x4_predictor.sv
`timescale 1ns/1ps
module intra4x4_predictor import intra4_pkg::*; #(
   parameter int PIX_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [3:0]            mode,
   input  logic [8*PIX_W-1:0]    top_pix,
   input  logic [4*PIX_W-1:0]    left_pix,
   input  logic [PIX_W-1:0]      corner_pix,
   input  logic                  top_ok,
   input  logic                  topright_ok,
   input  logic                  left_ok,
   output logic [16*PIX_W-1:0]   pred,
   output logic                  done
);
   localparam int LAT  = 6;
   localparam int CSTG = 4;

   generate
      if (PIX_W < 4 || PIX_W > 12) begin : g_bad_width
         $error("intra4x4_predictor: PIX_W must lie in 4..12");
      end
   endgenerate

   // stage 1: capture the boundary, substituting the upper-right run
   logic [NEDGE-1:0][PIX_W-1:0] cap_n, cap_e;
   always_comb begin
      for (int j = 0; j < 4; j++) cap_n[3-j] = left_pix[j*PIX_W +: PIX_W];
      cap_n[4] = corner_pix;
      for (int i = 0; i < 4; i++) begin
         cap_n[5+i] = top_pix[i*PIX_W +: PIX_W];
         cap_n[9+i] = topright_ok ? top_pix[(4+i)*PIX_W +: PIX_W]
                                  : top_pix[3*PIX_W +: PIX_W];
      end
   end

   logic [CSTG-1:0][3:0] mode_p;
   logic [CSTG-1:0]      top_p, left_p;
   logic [LAT-1:0]       vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_e <= '0; mode_p <= '0; top_p <= '0; left_p <= '0; vld <= '0;
      end else begin
         if (start) begin
            cap_e     <= cap_n;
            mode_p[0] <= mode;
            top_p[0]  <= top_ok;
            left_p[0] <= left_ok;
         end
         mode_p[CSTG-1:1] <= mode_p[CSTG-2:0];
         top_p[CSTG-1:1]  <= top_p[CSTG-2:0];
         left_p[CSTG-1:1] <= left_p[CSTG-2:0];
         vld <= {vld[LAT-2:0], start};
      end
   end

   logic [NF3-1:0][PIX_W+1:0]   tri_q;
   logic [PIX_W+1:0]            gend_q, lend_q, dct_q, dcl_q;
   logic [PIX_W+2:0]            dcb_q;
   logic [NAVG-1:0][PIX_W:0]    pair_q;
   logic [NRAW-1:0][PIX_W-1:0]  raw_q;
   logic [NCAND-1:0][PIX_W-1:0] cand_q;
   logic [NPIX-1:0][PIX_W-1:0]  pix_q;

   intra4_sums #(.PIX_W(PIX_W)) u_sums (
      .clk(clk), .rst_n(rst_n), .edge_q(cap_e), .tri_q(tri_q), .gend_q(gend_q),
      .lend_q(lend_q), .dcb_q(dcb_q), .dct_q(dct_q), .dcl_q(dcl_q),
      .pair_q(pair_q), .raw_q(raw_q));

   intra4_shift #(.PIX_W(PIX_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tri_q(tri_q), .gend_q(gend_q), .lend_q(lend_q),
      .dcb_q(dcb_q), .dct_q(dct_q), .dcl_q(dcl_q), .pair_q(pair_q), .raw_q(raw_q),
      .top_ok(top_p[2]), .left_ok(left_p[2]), .cand_q(cand_q));

   intra4_select #(.PIX_W(PIX_W)) u_select (
      .clk(clk), .rst_n(rst_n), .cand_q(cand_q), .mode_q(mode_p[3]),
      .top_ok(top_p[3]), .left_ok(left_p[3]), .load(vld[LAT-2]), .pix_q(pix_q));

   assign pred = pix_q;
   assign done = vld[LAT-1];

   // R1: every done traces back to a start six cycles earlier
   assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start, 6));

   // R2: result changes only together with done
   assert_pred_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (done || $stable(pred)));

   // R3: vertical copies the captured top row into the first and last rows
   assert_vert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mode_p[0], 5) == PM_VERT && $past(top_p[0], 5))
      |-> (pred[4*PIX_W-1:0] == $past({cap_e[8], cap_e[7], cap_e[6], cap_e[5]}, 5)
        && pred[16*PIX_W-1:12*PIX_W] == $past({cap_e[8], cap_e[7], cap_e[6], cap_e[5]}, 5)));

   // R4: horizontal repeats each left pixel along its row
   assert_horz_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mode_p[0], 5) == PM_HORZ && $past(left_p[0], 5))
      |-> (pred[4*PIX_W-1:0] == $past({4{cap_e[3]}}, 5)
        && pred[16*PIX_W-1:12*PIX_W] == $past({4{cap_e[0]}}, 5)));

   // R9: missing upper-right pixels become copies of top neighbour 3
   assert_tr_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !topright_ok)
      |=> (cap_e[9] == cap_e[8] && cap_e[10] == cap_e[8]
        && cap_e[11] == cap_e[8] && cap_e[12] == cap_e[8]));
endmodule

// File: tb/intra4x4_predictor_tb.sv
`timescale 1ns/1ps
module intra4x4_predictor_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   mode = '0;
   logic [63:0]  top_pix = '0;
   logic [31:0]  left_pix = '0;
   logic [7:0]   corner_pix = '0;
   logic         top_ok = 1'b0, topright_ok = 1'b0, left_ok = 1'b0;
   logic [127:0] pred;
   logic         done;

   int checks = 0;
   int errors = 0;
   int tv[9];   // top -1..7 at index i+1 (index 0 = corner)
   int lv[5];   // left -1..3 at index j+1 (index 0 = corner)
   logic [31:0] lfsr = 32'hACE1_2357;

   always #10 clk = ~clk;

   intra4x4_predictor u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .top_pix(top_pix),
      .left_pix(left_pix), .corner_pix(corner_pix), .top_ok(top_ok),
      .topright_ok(topright_ok), .left_ok(left_ok), .pred(pred), .done(done));

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rnd8();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr[7:0] ^ lfsr[23:16];
   endfunction

   function automatic int T(int i); return tv[i+1]; endfunction
   function automatic int L(int j); return lv[j+1]; endfunction
   function automatic int f3(int a, int b, int c); return (a + 2*b + c + 2) >> 2; endfunction
   function automatic int a2(int a, int b); return (a + b + 1) >> 1; endfunction

   function automatic int ref_pix(int m, int x, int y);
      int z;
      int s;
      case (m)
         0: return T(x);
         1: return L(y);
         2: begin
            s = 0;
            if (top_ok && left_ok) begin
               for (int k = 0; k < 4; k++) s += T(k) + L(k);
               return (s + 4) >> 3;
            end else if (top_ok) begin
               for (int k = 0; k < 4; k++) s += T(k);
               return (s + 2) >> 2;
            end else if (left_ok) begin
               for (int k = 0; k < 4; k++) s += L(k);
               return (s + 2) >> 2;
            end
            return 128;
         end
         3: if (x == 3 && y == 3) return f3(T(6), T(7), T(7));
            else return f3(T(x+y), T(x+y+1), T(x+y+2));
         4: if (x > y) return f3(T(x-y-2), T(x-y-1), T(x-y));
            else if (x < y) return f3(L(y-x-2), L(y-x-1), L(y-x));
            else return f3(T(0), T(-1), L(0));
         5: begin
            z = 2*x - y;
            if (z >= 0 && z % 2 == 0) return a2(T(x-(y>>1)-1), T(x-(y>>1)));
            if (z > 0) return f3(T(x-(y>>1)-2), T(x-(y>>1)-1), T(x-(y>>1)));
            if (z == -1) return f3(L(0), T(-1), T(0));
            return f3(L(y-1), L(y-2), L(y-3));
         end
         6: begin
            z = 2*y - x;
            if (z >= 0 && z % 2 == 0) return a2(L(y-(x>>1)-1), L(y-(x>>1)));
            if (z > 0) return f3(L(y-(x>>1)-2), L(y-(x>>1)-1), L(y-(x>>1)));
            if (z == -1) return f3(L(0), T(-1), T(0));
            return f3(T(x-1), T(x-2), T(x-3));
         end
         7: if (y % 2 == 0) return a2(T(x+(y>>1)), T(x+(y>>1)+1));
            else return f3(T(x+(y>>1)), T(x+(y>>1)+1), T(x+(y>>1)+2));
         default: begin
            z = x + 2*y;
            if (z > 5) return L(3);
            if (z == 5) return f3(L(2), L(3), L(3));
            if (z % 2 == 0) return a2(L(y+(x>>1)), L(y+(x>>1)+1));
            return f3(L(y+(x>>1)), L(y+(x>>1)+1), L(y+(x>>1)+2));
         end
      endcase
   endfunction

   function automatic int expected_mode(int m);
      bit need_t, need_l;
      if (m > 8) return 2;
      need_t = (m == 0 || m == 3 || m == 7 || m == 4 || m == 5 || m == 6);
      need_l = (m == 1 || m == 8 || m == 4 || m == 5 || m == 6);
      if ((need_t && !top_ok) || (need_l && !left_ok)) return 2;
      return m;
   endfunction

   task automatic load_pattern(int pat);
      for (int i = 0; i < 8; i++)
         top_pix[i*8 +: 8] = (pat == 0) ? 8'hFF : (pat == 1) ? 8'h00 : rnd8();
      for (int j = 0; j < 4; j++)
         left_pix[j*8 +: 8] = (pat == 0) ? 8'hFF : (pat == 1) ? 8'h00 : rnd8();
      corner_pix = (pat == 0) ? 8'hFF : (pat == 1) ? 8'h00 : rnd8();
   endtask

   task automatic run_case(int m, int av, bit hold_probe);
      int em;
      string tag;
      logic [127:0] exp_v, held;
      @(negedge clk);
      mode = 4'(m);
      top_ok = av[0]; left_ok = av[1]; topright_ok = av[2];
      tv[0] = corner_pix; lv[0] = corner_pix;
      for (int i = 0; i < 8; i++)
         tv[i+1] = (i >= 4 && !topright_ok) ? int'(top_pix[31:24]) : int'(top_pix[i*8 +: 8]);
      for (int j = 0; j < 4; j++) lv[j+1] = left_pix[j*8 +: 8];
      em = expected_mode(m);
      for (int p = 0; p < 16; p++) exp_v[p*8 +: 8] = 8'(ref_pix(em, p % 4, p / 4));
      case (em)
         0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5";
         3, 4: tag = "R6"; 5, 6: tag = "R7"; default: tag = "R8";
      endcase
      if (em != m) tag = "R10";
      else if (!topright_ok && (em == 3 || em == 7)) tag = "R9";
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R1 done early", {127'b0, done}, 128'd0);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R1 done due", {127'b0, done}, 128'd1);
      chk(pred == exp_v, tag, pred, exp_v);
      held = pred;
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R1 pulse width", {127'b0, done}, 128'd0);
      chk(pred == held, "R2 held after done", pred, held);
      if (hold_probe) begin
         mode = ~mode; top_ok = ~top_ok; left_ok = ~left_ok;
         top_pix = ~top_pix; left_pix = ~left_pix; corner_pix = ~corner_pix;
         repeat (7) @(posedge clk);
         @(negedge clk);
         chk(pred == held && done == 1'b0, "R2 inputs ignored without start", pred, held);
         top_pix = ~top_pix; left_pix = ~left_pix; corner_pix = ~corner_pix;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R11 done in reset", {127'b0, done}, 128'd0);
      chk(pred == '0, "R11 pred in reset", pred, 128'd0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0 && pred == '0, "R11 idle after reset", pred, 128'd0);
      // R12: layout of pixels and neighbours is exercised by every sweep case
      for (int pat = 0; pat < 6; pat++) begin
         load_pattern(pat);
         for (int av = 0; av < 8; av++)
            for (int m = 0; m < 16; m++)
               run_case(m, av, (m % 5) == 0);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule